// File: doc/BRIEF.md
# Downward-Growing Memory Stack

This block is a last-in first-out store built on a small word-addressed memory. A stack pointer starts at the stack-bottom value and moves toward lower addresses as words are added. A push request carries one data word; a pop request returns the newest word on a registered output one cycle later. The block keeps full and empty flags. It also shows the current top word and the pointer on output pins, so the client can watch the stack without popping it.

The request pins have no back-pressure. In every cycle the block either accepts a request or refuses it. A refused request changes nothing and gives a one-cycle error pulse. Requests that are refused: a push while full, a pop while empty, and a push and pop in the same cycle. The pop side is a plain valid strobe that the consumer must take when it appears. DEPTH must be a power of two. The stack-bottom value, one past the highest address, then wraps to address 0.

Top module: `lifo_stack`

## Requirements
- R1: After reset, sp is 0, empty is 1, full is 0, and err and pop_valid are 0.
- R2: An accepted push first lowers sp by one (modulo DEPTH) and then writes push_data at the new sp. On the next cycle tos_data shows that word.
- R3: An accepted pop reads the word at sp and then raises sp by one. The word appears on pop_data with pop_valid high for exactly the cycle after the request.
- R4: full rises when an accepted push brings sp to address 0. This happens after DEPTH pushes from empty.
- R5: Every accepted push clears empty.
- R6: Every accepted pop clears full. empty rises when a pop returns sp to the stack-bottom value 0.
- R7: A push while full is ignored. sp, the flags and tos_data stay the same, and err is 1 for the next cycle only.
- R8: A pop while empty is ignored. pop_valid stays 0, sp stays the same, and err pulses for one cycle.
- R9: A push and a pop requested in the same cycle are both refused, with no state change and a one-cycle err pulse.
- R10: Words come back in the reverse of the order in which they were pushed.
- R11: While empty is 1, tos_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request to push push_data |
| push_data | input | W | Word to push |
| pop_req | input | 1 | Request to pop the top word |
| pop_valid | output | 1 | pop_data holds a popped word this cycle |
| pop_data | output | W | Registered popped word |
| tos_data | output | W | Current top word, 0 when empty |
| sp | output | AW | Stack pointer |
| full | output | 1 | Stack holds DEPTH words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The hardest condition to reach is the full boundary with real data in every slot, followed by refused pushes and simultaneous requests while full. Balanced random traffic almost never gets to DEPTH words. The stimulus therefore runs a directed fill to full, then a push-heavy random phase that keeps hitting the ceiling, and then a pop-heavy phase that drains to empty. Every popped word and every top-of-stack value is compared against a bench model of the stack.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;
  // Decoded action for one cycle
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } stk_op_e;
endpackage

// File: rtl/lifo_stack_arb.sv
module lifo_stack_arb
  import lifo_stack_pkg::*;
(
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op
);
  always_comb begin
    if (push_req && pop_req)  op = OP_REJECT;
    else if (push_req)        op = full  ? OP_REJECT : OP_PUSH;
    else if (pop_req)         op = empty ? OP_REJECT : OP_POP;
    else                      op = OP_NONE;
  end
endmodule

// File: rtl/lifo_stack_ptr.sv
module lifo_stack_ptr
  import lifo_stack_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op,
  output logic [AW-1:0] sp,
  output logic          full,
  output logic          empty,
  output logic          err
);
  // DEPTH is a power of two: one past the top address wraps to zero
  localparam logic [AW-1:0] SP_BOTTOM = '0;
  localparam logic [AW-1:0] ADDR_LOW  = '0;

  logic [AW-1:0] sp_dec, sp_inc;
  assign sp_dec = sp - AW'(1);
  assign sp_inc = sp + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= SP_BOTTOM;
      full  <= 1'b0;
      empty <= 1'b1;
      err   <= 1'b0;
    end else begin
      err <= (op == OP_REJECT);
      case (op)
        OP_PUSH: begin
          sp    <= sp_dec;
          full  <= (sp_dec == ADDR_LOW);
          empty <= 1'b0;
        end
        OP_POP: begin
          sp    <= sp_inc;
          full  <= 1'b0;
          empty <= (sp_inc == SP_BOTTOM);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lifo_stack_mem.sv
module lifo_stack_mem #(
  parameter int W = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import lifo_stack_pkg::*;
#(
  parameter int W = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [W-1:0]  push_data,
  input  logic          pop_req,
  output logic          pop_valid,
  output logic [W-1:0]  pop_data,
  output logic [W-1:0]  tos_data,
  output logic [AW-1:0] sp,
  output logic          full,
  output logic          empty,
  output logic          err
);
  stk_op_e       op;
  logic [W-1:0]  rd_word;
  logic [AW-1:0] wr_addr;

  lifo_stack_arb arb_i (
    .push_req(push_req), .pop_req(pop_req),
    .full(full), .empty(empty), .op(op)
  );

  lifo_stack_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .op(op),
    .sp(sp), .full(full), .empty(empty), .err(err)
  );

  // pre-decrement: the write lands one below the current pointer
  assign wr_addr = sp - AW'(1);

  lifo_stack_mem #(.W(W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .we(op == OP_PUSH), .waddr(wr_addr),
    .wdata(push_data), .raddr(sp), .rdata(rd_word)
  );

  assign tos_data = empty ? '0 : rd_word;

  // read before increment: capture the word at the old pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      pop_valid <= (op == OP_POP);
      if (op == OP_POP) pop_data <= rd_word;
    end
  end
endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
  parameter int W = 16,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic [W-1:0]  push_data,
  input logic          pop_req,
  input logic          pop_valid,
  input logic [W-1:0]  pop_data,
  input logic [W-1:0]  tos_data,
  input logic [AW-1:0] sp,
  input logic          full,
  input logic          empty,
  input logic          err
);
  logic acc_push, acc_pop;
  assign acc_push = push_req && !pop_req && !full;
  assign acc_pop  = pop_req && !push_req && !empty;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (sp == '0 && empty && !full && !err && !pop_valid));

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push |=> sp == $past(sp) - AW'(1));

  p_push_tos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push |=> tos_data == $past(push_data));

  p_pop_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pop |=> (pop_valid && pop_data == $past(tos_data) && sp == $past(sp) + AW'(1)));

  p_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_push && sp == AW'(1)) |=> full);

  p_push_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push |=> !empty);

  p_pop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pop |=> !full);

  p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && full) |=> (err && full && sp == $past(sp)));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && empty) |=> (err && !pop_valid && sp == $past(sp)));

  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> (err && !pop_valid && sp == $past(sp)));

  p_tos_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> tos_data == '0);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

bind lifo_stack lifo_stack_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
  .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
  .tos_data(tos_data), .sp(sp), .full(full), .empty(empty), .err(err)
);

// File: tb/lifo_stack_tb_top.sv
module lifo_stack_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_req = 1'b0;
  logic [W-1:0]  push_data = '0;
  logic          pop_req = 1'b0;
  logic          pop_valid;
  logic [W-1:0]  pop_data;
  logic [W-1:0]  tos_data;
  logic [AW-1:0] sp;
  logic          full, empty, err;

  lifo_stack #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
    .tos_data(tos_data), .sp(sp), .full(full), .empty(empty), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  logic [W-1:0] model[$];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_sp(int n);
    return AW'(DEPTH - n);
  endfunction

  function automatic logic [W-1:0] exp_tos();
    return (model.size() == 0) ? '0 : model[$];
  endfunction

  task automatic step(bit push, bit pop, logic [W-1:0] d);
    int n;
    bit ok_push, ok_pop, bad;
    logic [W-1:0] exp_pd;
    string rq;
    n = model.size();
    ok_push = push && !pop && n < DEPTH;
    ok_pop  = pop && !push && n > 0;
    bad     = (push || pop) && !ok_push && !ok_pop;
    exp_pd  = '0;
    @(negedge clk);
    push_req = push; pop_req = pop; push_data = d;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    if (ok_push) model.push_back(d);
    if (ok_pop) exp_pd = model.pop_back();
    rq = ok_push ? "R2" : ok_pop ? "R3" : (push && pop) ? "R9" :
         push ? "R7" : pop ? "R8" : "R3";
    check(rq, "err", 32'(err), 32'(bad));
    check(rq, "pop_valid", 32'(pop_valid), 32'(ok_pop));
    if (ok_pop) check("R10", "pop_data", 32'(pop_data), 32'(exp_pd));
    check(rq, "sp", 32'(sp), 32'(exp_sp(model.size())));
    check(ok_push ? "R4" : "R6", "full", 32'(full), 32'(model.size() == DEPTH));
    check(ok_push ? "R5" : "R6", "empty", 32'(empty), 32'(model.size() == 0));
    check(model.size() == 0 ? "R11" : "R2", "tos_data", 32'(tos_data), 32'(exp_tos()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    check("R1", "sp", 32'(sp), 32'(0));
    check("R1", "empty", 32'(empty), 32'(1));
    check("R1", "full", 32'(full), 32'(0));
    check("R1", "err", 32'(err), 32'(0));
    check("R1", "pop_valid", 32'(pop_valid), 32'(0));
    check("R11", "tos_data", 32'(tos_data), 32'(0));

    step(1'b0, 1'b1, '0);                 // R8 pop on empty
    step(1'b1, 1'b1, 16'h1111);           // R9 both while empty
    step(1'b1, 1'b0, 16'hA001);
    step(1'b1, 1'b0, 16'hA002);
    step(1'b1, 1'b0, 16'hA003);
    step(1'b1, 1'b1, 16'h2222);           // R9 both while holding data
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0);  // R10 order
    step(1'b0, 1'b1, '0);                 // R8 again after draining

    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, W'(16'hC000 + i)); // R4 fill
    step(1'b1, 1'b0, 16'hDEAD);           // R7 push while full
    step(1'b1, 1'b1, 16'hBEEF);           // R9 both while full
    step(1'b0, 1'b1, '0);                 // R6 pop clears full
    step(1'b1, 1'b0, 16'h5A5A);           // R4 full again

    for (int i = 0; i < 1500; i++) begin  // push-heavy random
      int r = $urandom % 16;
      step(r < 11 || r == 15, r >= 11, W'($urandom));
    end
    for (int i = 0; i < 1500; i++) begin  // pop-heavy random
      int r = $urandom % 16;
      step(r < 4 || r == 15, r >= 4, W'($urandom));
    end
    while (model.size() > 0) step(1'b0, 1'b1, '0);     // R6 drain to empty
    step(1'b0, 1'b1, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule